// File: doc/BRIEF.md
# Flash command interface controller

This block is the command-register front end of a byte-wide flash memory. A host drives it with active-low chip enable, output enable and write enable strobes. These may change at any time and are brought into the system clock domain by a two-stage synchroniser. Each accepted write cycle carries a one-byte command or operand. A state machine decodes these and sets what a later read cycle returns: array data, identifier codes or verify data. The state machine also steps through erase and program operations. The storage array is built from on-chip registers. The address port is 17 bits wide, enough for 128K bytes, while a parameter sets how many bytes are actually built.

Erase and program are open-ended. An operation starts with a setup write and a start write. It ends when the host writes the matching verify command. If that command never comes, an internal stop timer of `STOP_CYC` clock cycles ends the operation. The device then parks in an inactive state, which only a verify command or a double reset releases. The array changes only when the operation ends. Writes count only while `vpp_en` is high. Without it the block is a read-only memory. The data bus is split into `dq_in`, `dq_out` and a drive enable `dq_oe`, which a pad ring turns into a three-state pin. All pins are plain control and data. The strobes set the pace and there is no back-pressure.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset `dq_oe` is low, the block is in array-read mode and every array byte reads 0xFF.
- R2: `dq_oe` is high only while both `ce_n` and `oe_n` are low. If either is high, the bus is released (`dq_oe` low).
- R3: In array-read mode a read returns the byte at the low `ARR_W` bits of `addr`. Higher address bits are ignored, so with `ARR_W`=6, address 0x45 reads byte 5.
- R4: While `vpp_en` is low every write cycle is ignored. No command changes the mode and no byte is programmed.
- R5: The address of a write cycle is taken when `we_n` falls and the data when `we_n` rises. Changes to either while `we_n` is low, before the relevant edge, have no effect.
- R6: Command 0x90 selects identifier reads. Address 0 returns `MFR_ID`, address 1 returns `DEV_ID` and any other address returns 0x00. Command 0x00 returns the block to array reads.
- R7: Erase is 0x20 followed by 0x20. The 0xA0 command then sets every byte to 0xFF and enters erase-verify. Erase-verify reads return the byte at the address of the 0xA0 write, whatever the pins say. Any other second byte after 0x20 (except 0xFF) cancels the setup and returns to array reads.
- R8: Program is 0x40 followed by a write of the target address and data. The 0xC0 command then stores old AND data at the target. Program-verify reads return the byte at the address of the 0xC0 write. A byte never gains a 1 bit except through erase.
- R9: While an erase or program is running, the array is unchanged. After `STOP_CYC` cycles without a verify command, the operation is applied and the block parks inactive. While parked, writes other than 0xA0, 0xC0 and 0xFF are ignored, so for example 0x90 still leaves array reads.
- R10: A verify command written after the stop timer expired leaves the same array contents as one written before expiry.
- R11: Two consecutive 0xFF writes return the block to array reads and abandon a running operation without applying it. A single 0xFF followed by another command does not reset, and that command is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| vpp_en | input | 1 | High-voltage present; gates all writes |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Data bus input (command or operand) |
| dq_out | output | 8 | Data bus output value |
| dq_oe | output | 1 | Data bus drive enable (low = high impedance) |

## Verification
Fixed command sequences check identifier reads against array reads, and a program of 0x5A followed by 0x0F checks that the AND rule gives 0x0A and not an overwrite. Verify reads use pin addresses that differ from the verify address, so reading the array at the latched verify address can be told apart from reading at the pins. Program and erase are each run both with an immediate verify and past the stop timer. This separates "applied at end" from "applied at start" and from "never applied". Reads taken during the run and after the parked state show which behaviour occurred. Writes with `vpp_en` low, a second 0xFF reset during a pulse, a single 0xFF and address/data changes while `we_n` is low each check a different way in which a write can wrongly take effect.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;
  typedef enum logic [3:0] {
    ST_READ, ST_IDENT, ST_ER_SETUP, ST_ER_RUN, ST_ER_VFY,
    ST_PG_SETUP, ST_PG_RUN, ST_PG_VFY, ST_PARKED
  } fstate_t;

  localparam logic [7:0] CMD_READ   = 8'h00;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_ERASE  = 8'h20;
  localparam logic [7:0] CMD_ER_VFY = 8'hA0;
  localparam logic [7:0] CMD_PROG   = 8'h40;
  localparam logic [7:0] CMD_PG_VFY = 8'hC0;
  localparam logic [7:0] CMD_RESET  = 8'hFF;
endpackage

// File: rtl/flashcmd_sync.sv
module flashcmd_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= '1;
      else        stg[s] <= (s == 0) ? d : stg[(s == 0) ? 0 : s - 1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/flashcmd_timer.sv
module flashcmd_timer #(
  parameter int STOP_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic expired
);
  localparam int CW = $clog2(STOP_CYC + 1);
  logic [CW-1:0] cnt;
  logic          running;

  assign expired = running && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (start) begin
      cnt     <= CW'(STOP_CYC - 1);
      running <= 1'b1;
    end else if (cancel || expired) begin
      running <= 1'b0;
    end else if (running) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/flashcmd_array.sv
module flashcmd_array #(
  parameter int ARR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             erase_all,
  input  logic             prog_en,
  input  logic [ARR_W-1:0] prog_addr,
  input  logic [7:0]       prog_data,
  input  logic [ARR_W-1:0] rd_addr,
  output logic [7:0]       rd_data
);
  localparam int DEPTH = 1 << ARR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n || erase_all) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (prog_en) begin
      mem[prog_addr] <= mem[prog_addr] & prog_data;
    end
  end

  assign rd_data = mem[rd_addr];

  // R8
  bits_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_all |=> ((mem[0] & ~$past(mem[0])) == 8'h00));

  // R7
  erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_all |=> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flashcmd_pkg::*;
#(
  parameter int         ADDR_W   = 17,
  parameter int         ARR_W    = 6,
  parameter int         STOP_CYC = 64,
  parameter logic [7:0] MFR_ID   = 8'hA7,
  parameter logic [7:0] DEV_ID   = 8'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              vpp_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  output logic              dq_oe
);
  logic [2:0] strobe_s;
  logic ce_s, oe_s, we_s, we_prev;
  fstate_t state;
  logic rst_arm;
  logic [ARR_W-1:0] addr_lat, pg_addr, vfy_addr, rd_addr;
  logic [7:0] pg_data, arr_rdata, id_byte;
  logic we_fall, we_rise, wr, in_run, vfy_hit, reset_hit, apply;
  logic tmr_start, tmr_cancel, tmr_exp, erase_all, prog_en;

  flashcmd_sync #(.N(3), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ce_n, oe_n, we_n}), .q(strobe_s));
  assign {ce_s, oe_s, we_s} = strobe_s;

  always_ff @(posedge clk) begin
    if (!rst_n) we_prev <= 1'b1;
    else        we_prev <= we_s;
  end

  assign we_fall = we_prev && !we_s;
  assign we_rise = !we_prev && we_s;
  assign wr      = we_rise && !ce_s && vpp_en;
  assign in_run  = (state == ST_ER_RUN) || (state == ST_PG_RUN);

  assign vfy_hit = wr && (((state == ST_ER_RUN) && (dq_in == CMD_ER_VFY)) ||
                          ((state == ST_PG_RUN) && (dq_in == CMD_PG_VFY)));
  assign reset_hit = wr && (state != ST_PG_SETUP) && (dq_in == CMD_RESET) && rst_arm;
  assign tmr_start = wr && (((state == ST_ER_SETUP) && (dq_in == CMD_ERASE)) ||
                            (state == ST_PG_SETUP));
  assign tmr_cancel = vfy_hit || reset_hit;
  assign apply      = vfy_hit || (tmr_exp && in_run && !reset_hit);
  assign erase_all  = apply && (state == ST_ER_RUN);
  assign prog_en    = apply && (state == ST_PG_RUN);

  flashcmd_timer #(.STOP_CYC(STOP_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .cancel(tmr_cancel),
    .expired(tmr_exp));

  assign rd_addr = ((state == ST_ER_VFY) || (state == ST_PG_VFY)) ?
                   vfy_addr : addr[ARR_W-1:0];

  flashcmd_array #(.ARR_W(ARR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .erase_all(erase_all), .prog_en(prog_en),
    .prog_addr(pg_addr), .prog_data(pg_data), .rd_addr(rd_addr),
    .rd_data(arr_rdata));

  always_comb begin
    if (addr == ADDR_W'(0))      id_byte = MFR_ID;
    else if (addr == ADDR_W'(1)) id_byte = DEV_ID;
    else                         id_byte = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_READ;
      rst_arm  <= 1'b0;
      addr_lat <= '0;
      pg_addr  <= '0;
      pg_data  <= 8'hFF;
      vfy_addr <= '0;
      dq_out   <= 8'h00;
      dq_oe    <= 1'b0;
    end else begin
      dq_oe  <= !ce_s && !oe_s;
      dq_out <= (state == ST_IDENT) ? id_byte : arr_rdata;
      if (we_fall && !ce_s) addr_lat <= addr[ARR_W-1:0];
      if (tmr_exp && in_run) state <= ST_PARKED;
      if (wr) begin
        if (state == ST_PG_SETUP) begin
          pg_addr <= addr_lat;
          pg_data <= dq_in;
          rst_arm <= 1'b0;
          state   <= ST_PG_RUN;
        end else if (dq_in == CMD_RESET) begin
          rst_arm <= !rst_arm;
          if (rst_arm) state <= ST_READ;
        end else begin
          rst_arm <= 1'b0;
          case (state)
            ST_ER_SETUP: state <= (dq_in == CMD_ERASE) ? ST_ER_RUN : ST_READ;
            ST_ER_RUN, ST_PG_RUN, ST_PARKED: begin
              if ((dq_in == CMD_ER_VFY) && (state != ST_PG_RUN)) begin
                state <= ST_ER_VFY; vfy_addr <= addr_lat;
              end else if ((dq_in == CMD_PG_VFY) && (state != ST_ER_RUN)) begin
                state <= ST_PG_VFY; vfy_addr <= addr_lat;
              end
            end
            default: begin
              case (dq_in)
                CMD_READ:   state <= ST_READ;
                CMD_IDENT:  state <= ST_IDENT;
                CMD_ERASE:  state <= ST_ER_SETUP;
                CMD_PROG:   state <= ST_PG_SETUP;
                CMD_ER_VFY: begin state <= ST_ER_VFY; vfy_addr <= addr_lat; end
                CMD_PG_VFY: begin state <= ST_PG_VFY; vfy_addr <= addr_lat; end
                default: ;
              endcase
            end
          endcase
        end
      end
    end
  end

  // R4
  vpp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_rise && !vpp_en && !tmr_exp) |=> $stable(state));

  // R9
  exp_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_exp |-> in_run);

  // R9
  parked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_PARKED) && !(wr && ((dq_in == CMD_ER_VFY) ||
      (dq_in == CMD_PG_VFY) || (dq_in == CMD_RESET)))) |=> (state == ST_PARKED));

  // R11
  reset_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_hit |=> (state == ST_READ));
endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  localparam int STOP_CYC = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, vpp_en = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  dq_in = '0;
  logic [7:0]  dq_out;
  logic        dq_oe;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(17), .ARR_W(6), .STOP_CYC(STOP_CYC),
                   .MFR_ID(8'hA7), .DEV_ID(8'h3C)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .vpp_en(vpp_en), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe));

  // {req[31:28], op[27:24] (1 = read check), addr[23:16], data[15:8], exp[7:0]}
  localparam int NV = 26;
  localparam logic [31:0] VEC [NV] = '{
    32'h1100_00FF,                                            // R1 erased at reset
    32'h6000_9000, 32'h6100_00A7, 32'h6101_003C,              // R6 identifier
    32'h6000_0000, 32'h6101_00FF,                             // R6 back to array
    32'h8000_4000, 32'h8005_5A00, 32'h8005_C000, 32'h8109_005A, // R8 verify at 5
    32'h3000_0000, 32'h3105_005A, 32'h3145_005A, 32'h3106_00FF, // R3 reads, wrap
    32'h8000_4000, 32'h8005_0F00, 32'h8005_C000, 32'h8105_000A, // R8 AND rule
    32'h7000_2000, 32'h7000_2000, 32'h7005_A000, 32'h7105_00FF, // R7 erase
    32'h7000_0000, 32'h713F_00FF,                             // R7 last byte
    32'h7000_2000, 32'h7000_9000                              // R7 setup cancel
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [16:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; dq_in = d; ce_n = 1'b0;
    repeat (3) @(negedge clk); we_n = 1'b0;
    repeat (5) @(negedge clk); we_n = 1'b1;
    repeat (5) @(negedge clk); ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_read(input logic [16:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (6) @(negedge clk);
    v = dq_out;
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v, early_val, late_val;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 dq_oe after reset", {7'd0, dq_oe}, 8'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) begin
        bus_read({9'd0, VEC[i][23:16]}, v);
        check($sformatf("R%0d vector %0d", VEC[i][31:28], i), v, VEC[i][7:0]);
      end else begin
        bus_write({9'd0, VEC[i][23:16]}, VEC[i][15:8]);
      end
    end
    // R7 cancelled setup: 0x90 was not decoded as identifier
    bus_read(17'd0, v); check("R7 setup cancelled", v, 8'hFF);

    // R2 bus release combinations
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; repeat (6) @(negedge clk);
    check("R2 oe high", {7'd0, dq_oe}, 8'd0);
    ce_n = 1'b1; oe_n = 1'b0; repeat (6) @(negedge clk);
    check("R2 ce high", {7'd0, dq_oe}, 8'd0);
    ce_n = 1'b0; repeat (6) @(negedge clk);
    check("R2 both low", {7'd0, dq_oe}, 8'd1);
    ce_n = 1'b1; oe_n = 1'b1; repeat (6) @(negedge clk);
    check("R2 released", {7'd0, dq_oe}, 8'd0);

    // R4 writes ignored without high voltage
    vpp_en = 1'b0;
    bus_write(17'd0, 8'h90);
    bus_read(17'd0, v); check("R4 ident ignored", v, 8'hFF);
    bus_write(17'd0, 8'h40); bus_write(17'd7, 8'h00);
    vpp_en = 1'b1;
    bus_write(17'd7, 8'hC0);
    bus_write(17'd0, 8'h00);
    bus_read(17'd7, v); check("R4 program ignored", v, 8'hFF);

    // R5 address at falling edge, data at rising edge
    bus_write(17'd0, 8'h40);
    @(negedge clk); addr = 17'd10; dq_in = 8'hFF; ce_n = 1'b0;
    repeat (3) @(negedge clk); we_n = 1'b0;
    repeat (5) @(negedge clk); addr = 17'd11; dq_in = 8'h33;
    repeat (3) @(negedge clk); we_n = 1'b1;
    repeat (5) @(negedge clk); ce_n = 1'b1;
    repeat (2) @(negedge clk);
    bus_write(17'd10, 8'hC0);
    bus_write(17'd0, 8'h00);
    bus_read(17'd10, v); check("R5 data at rise, addr at fall", v, 8'h33);
    bus_read(17'd11, v); check("R5 late address unused", v, 8'hFF);

    // R9 program closed by the stop timer
    bus_write(17'd0, 8'h40); bus_write(17'd20, 8'h81);
    bus_read(17'd20, v); check("R9 unchanged during run", v, 8'hFF);
    repeat (STOP_CYC + 20) @(negedge clk);
    bus_read(17'd20, v); check("R9 applied at expiry", v, 8'h81);
    bus_write(17'd0, 8'h90);
    bus_read(17'd0, v); check("R9 parked ignores 0x90", v, 8'hFF);
    bus_write(17'd20, 8'hC0);
    bus_read(17'd21, v); late_val = v;
    check("R9 verify releases park", v, 8'h81);

    // R10 early verify gives the same contents
    bus_write(17'd0, 8'h40); bus_write(17'd30, 8'h81); bus_write(17'd30, 8'hC0);
    bus_read(17'd31, v); early_val = v;
    check("R10 early vs late verify", early_val, late_val);
    bus_write(17'd0, 8'h00);
    bus_read(17'd30, v); check("R10 early verify stored", v, 8'h81);

    // R11 double reset abandons the pulse
    bus_write(17'd0, 8'h40); bus_write(17'd40, 8'h12);
    bus_write(17'd0, 8'hFF); bus_write(17'd0, 8'hFF);
    repeat (STOP_CYC + 20) @(negedge clk);
    bus_read(17'd40, v); check("R11 pulse abandoned", v, 8'hFF);
    bus_write(17'd0, 8'hFF); bus_write(17'd0, 8'h90);
    bus_read(17'd1, v); check("R11 single reset then ident", v, 8'h3C);
    bus_write(17'd0, 8'h00);

    // R9 erase closed by the stop timer, R10 verify afterwards
    bus_write(17'd0, 8'h20); bus_write(17'd0, 8'h20);
    bus_read(17'd20, v); check("R9 erase run unchanged", v, 8'h81);
    repeat (STOP_CYC + 20) @(negedge clk);
    bus_read(17'd20, v); check("R9 erase at expiry", v, 8'hFF);
    bus_write(17'd20, 8'hA0);
    bus_read(17'd30, v); check("R10 erase verify after expiry", v, 8'hFF);

    summary();
    $finish;
  end
endmodule